// File: doc/BRIEF.md
# Compare and Rollover Timer

This block is a memory-mapped up-counting timer with one compare channel. A counter advances by one on every cycle in which the tick-enable input is high and the timer is enabled. It raises a compare flag when the count reaches a programmed value and a rollover flag when the count wraps from its all-ones value. A single level interrupt is formed from the two flags, gated by per-flag enables and by the timer enable.

Software reaches the block through a word-addressed register port. Writes take effect at the clock edge. Reads are combinational and have no side effects.

A control write can also trigger a software reset. It clears the working state and keeps most of the configuration. A separate enable-mode bit chooses whether turning the timer on restarts the count from zero. Another control bit chooses between two behaviours after a compare match: restart from zero, or keep running to the wrap.

Top module: `cmp_rollover_timer`

## Requirements
- R1: After hardware reset every register reads zero and `irq` is low.
- R2: Word offsets 0 (control), 1 (prescaler, stored only), 3 (interrupt enable) and 4 (compare, CNT_W bits, zero-extended) read back what was written. Offset 2 reads the flags at bit 0 (compare) and bit 5 (rollover), with all other bits zero. Offset 9 reads the counter and ignores writes. Every other offset reads zero and ignores writes.
- R3: The counter changes only on a cycle with `tick` high while control bit 0 (enable) is set; otherwise it holds its value.
- R4: A control write that sets bit 0 while the stored bit 0 is clear loads the counter with zero if bit 1 of the written word is set. If bit 1 is clear, the counter resumes from its held value.
- R5: A control write with bit 15 set is a software reset. It clears the flags, prescaler, interrupt enable, compare value and counter. Control keeps its stored bits except bits 0, 2, 3 and 4, which clear. The written word is discarded, and bit 15 never reads as 1.
- R6: On a counting tick whose new count equals the compare value, status bit 0 sets.
- R7: With control bit 9 clear (restart), a counting tick taken while the counter equals the compare value loads zero. With bit 9 set (free-run), the counter keeps incrementing.
- R8: A counting tick taken at the all-ones count sets status bit 5. In free-run mode the counter wraps to zero.
- R9: Writing offset 2 clears each of status bits 0 and 5 whose written bit is 1. Written zeros and all other bits have no effect.
- R10: If a flag's set event and its write-one-to-clear happen in the same cycle, the flag ends set.
- R11: `irq` is high exactly when control bit 0 is set and (status AND interrupt-enable AND bits {5,0}) is nonzero. It follows each register change in the same cycle that the change becomes visible.
- R12: A compare write is used by every counting tick in a later cycle; a tick in the same cycle as the write uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| tick | input | 1 | Count enable from the divided peripheral clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| irq | output | 1 | Level interrupt |

## Verification
The counter is visible on a read the cycle after any tick. A wrong increment, missed restart or skipped enable-mode clear therefore shows as a wrong count at the next read, and the error persists in every later value. A flag that sets late or clears wrongly shows on `irq` in the same cycle, as long as its interrupt enable is on. With the enable off, it shows at the next status read. A software reset that keeps or drops the wrong control bits appears at the next control read, and in the counting behaviour from the next tick on.

// File: rtl/cmp_tmr_pkg.sv
package cmp_tmr_pkg;
  localparam int BUS_W = 32;

  // register word offsets
  localparam logic [3:0] OFS_CTRL = 4'd0;
  localparam logic [3:0] OFS_PRE  = 4'd1;
  localparam logic [3:0] OFS_STAT = 4'd2;
  localparam logic [3:0] OFS_IEN  = 4'd3;
  localparam logic [3:0] OFS_CMP  = 4'd4;
  localparam logic [3:0] OFS_CNT  = 4'd9;

  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_EMODE = 1;
  localparam int B_DBG   = 2;
  localparam int B_WAIT  = 3;
  localparam int B_DOZE  = 4;
  localparam int B_FREE  = 9;
  localparam int B_SRST  = 15;

  // status bit positions
  localparam int SB_CMP = 0;
  localparam int SB_ROV = 5;

  localparam logic [BUS_W-1:0] SRST_CLR_MASK =
    (BUS_W'(1) << B_EN) | (BUS_W'(1) << B_DBG) |
    (BUS_W'(1) << B_WAIT) | (BUS_W'(1) << B_DOZE);

  // control value kept across a software reset
  function automatic logic [BUS_W-1:0] ctrl_after_srst(input logic [BUS_W-1:0] c);
    return c & ~SRST_CLR_MASK & ~(BUS_W'(1) << B_SRST);
  endfunction

  // interrupt combine: flags[0]=compare, flags[1]=rollover
  function automatic logic irq_combine(input logic en, input logic [1:0] flags,
                                       input logic [BUS_W-1:0] ien);
    return en & ((flags[0] & ien[SB_CMP]) | (flags[1] & ien[SB_ROV]));
  endfunction

  // place the two flags at their status positions
  function automatic logic [BUS_W-1:0] stat_word(input logic [1:0] flags);
    logic [BUS_W-1:0] w;
    w = '0;
    w[SB_CMP] = flags[0];
    w[SB_ROV] = flags[1];
    return w;
  endfunction
endpackage

// File: rtl/cmp_tmr_regs.sv
module cmp_tmr_regs
  import cmp_tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  ctrl_q,
  output logic [BUS_W-1:0]  pre_q,
  output logic [BUS_W-1:0]  ien_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              soft_rst,
  output logic              cnt_clear,
  output logic [1:0]        stat_clr
);
  logic hit_ctrl, hit_pre, hit_stat, hit_ien, hit_cmp;

  assign hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign hit_pre  = wr_en && (addr == ADDR_W'(OFS_PRE));
  assign hit_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign hit_ien  = wr_en && (addr == ADDR_W'(OFS_IEN));
  assign hit_cmp  = wr_en && (addr == ADDR_W'(OFS_CMP));

  // software reset event: a control write carrying the reset bit
  assign soft_rst  = hit_ctrl && wdata[B_SRST];
  // enable rising edge with enable-mode requests a fresh count
  assign cnt_clear = hit_ctrl && !wdata[B_SRST] && !ctrl_q[B_EN] &&
                     wdata[B_EN] && wdata[B_EMODE];
  // write-one-to-clear mask for the two flags
  assign stat_clr  = hit_stat ? {wdata[SB_ROV], wdata[SB_CMP]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '0;
    end else if (soft_rst) begin
      ctrl_q <= ctrl_after_srst(ctrl_q);
      pre_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= wdata & ~(BUS_W'(1) << B_SRST);
      if (hit_pre)  pre_q  <= wdata;
      if (hit_ien)  ien_q  <= wdata;
      if (hit_cmp)  cmp_q  <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/cmp_tmr_counter.sv
module cmp_tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic             soft_rst,
  input  logic             cnt_clear,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_ev,
  output logic             rov_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // next count on a counting tick
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] limit,
                                                  input logic reload);
    if (reload && (cur == limit)) return '0;
    return cur + 1'b1;
  endfunction

  logic             step;
  logic [CNT_W-1:0] cnt_nxt;

  assign step     = run && tick;
  assign cnt_nxt  = next_count(cnt_q, cmp, restart);
  assign match_ev = step && (cnt_nxt == cmp);
  assign rov_ev   = step && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (soft_rst || cnt_clear) cnt_q <= '0;
    else if (step)                  cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/cmp_tmr_flags.sv
module cmp_tmr_flags
  import cmp_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             match_ev,
  input  logic             rov_ev,
  input  logic [1:0]       stat_clr,
  input  logic             en,
  input  logic [BUS_W-1:0] ien,
  output logic [1:0]       flags_q,
  output logic             irq
);
  logic [1:0] set_ev;
  assign set_ev = {rov_ev, match_ev};

  // set wins over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (soft_rst) flags_q <= '0;
    else               flags_q <= (flags_q & ~stat_clr) | set_ev;
  end

  assign irq = irq_combine(en, flags_q, ien);
endmodule

// File: rtl/cmp_rollover_timer.sv
module cmp_rollover_timer
  import cmp_tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic [BUS_W-1:0] ctrl_q, pre_q, ien_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic             soft_rst, cnt_clear, match_ev, rov_ev;
  logic [1:0]       stat_clr, flags_q;
  logic             run, restart;

  assign run     = ctrl_q[B_EN];
  assign restart = !ctrl_q[B_FREE];

  cmp_tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_q(ctrl_q), .pre_q(pre_q), .ien_q(ien_q), .cmp_q(cmp_q),
    .soft_rst(soft_rst), .cnt_clear(cnt_clear), .stat_clr(stat_clr)
  );

  cmp_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .restart(restart),
    .soft_rst(soft_rst), .cnt_clear(cnt_clear), .cmp(cmp_q),
    .cnt_q(cnt_q), .match_ev(match_ev), .rov_ev(rov_ev)
  );

  cmp_tmr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .match_ev(match_ev),
    .rov_ev(rov_ev), .stat_clr(stat_clr), .en(run), .ien(ien_q),
    .flags_q(flags_q), .irq(irq)
  );

  // side-effect free read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_W'(OFS_CTRL): rdata = ctrl_q;
        ADDR_W'(OFS_PRE):  rdata = pre_q;
        ADDR_W'(OFS_STAT): rdata = stat_word(flags_q);
        ADDR_W'(OFS_IEN):  rdata = ien_q;
        ADDR_W'(OFS_CMP):  rdata = BUS_W'(cmp_q);
        ADDR_W'(OFS_CNT):  rdata = BUS_W'(cnt_q);
        default:           rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmp_rollover_timer_chk.sv
module cmp_rollover_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic             en,
  input logic             srst_bit,
  input logic             restart,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic [1:0]       flags,
  input logic             match_ev,
  input logic             rov_ev,
  input logic             soft_rst,
  input logic             irq
);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !wr_en && !(restart && cnt == cmp)) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !wr_en && restart && cnt == cmp) |=> cnt == '0);

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !wr_en && !restart && cnt == {CNT_W{1'b1}}) |=> cnt == '0);

  a_r10_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && !soft_rst) |=> flags[0]);

  a_r8_rov_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rov_ev && !soft_rst) |=> flags[1]);

  a_r5_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cnt == '0 && flags == 2'b00 && !en));

  a_r5_bit_never_set: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_bit);

  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && (flags != 2'b00)));
endmodule

bind cmp_rollover_timer cmp_rollover_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .en(ctrl_q[0]), .srst_bit(ctrl_q[15]), .restart(restart),
  .cnt(cnt_q), .cmp(cmp_q), .flags(flags_q), .match_ev(match_ev),
  .rov_ev(rov_ev), .soft_rst(soft_rst), .irq(irq)
);

// File: tb/test_cmp_rollover_timer.sv
`timescale 1ns/1ps
module test_cmp_rollover_timer;
  localparam int CW = 8;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  cmp_rollover_timer #(.CNT_W(CW), .ADDR_W(4)) i_cmp_rollover_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // reference state
  logic [31:0]   m_ctrl = '0, m_pre = '0, m_ien = '0, m_sr = '0;
  logic [CW-1:0] m_cmp = '0, m_cnt = '0;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return m_pre;
      4'd2: return m_sr;
      4'd3: return m_ien;
      4'd4: return {{(32-CW){1'b0}}, m_cmp};
      4'd9: return {{(32-CW){1'b0}}, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_irq();
    return m_ctrl[0] && ((m_sr & m_ien & 32'h21) != 0);
  endfunction

  task automatic m_step(input logic wr, input logic [3:0] a,
                        input logic [31:0] d, input logic tk);
    logic [CW-1:0] nc;
    logic [31:0] setm, clrm;
    if (wr && a == 4'd0 && d[15]) begin
      m_ctrl = m_ctrl & ~32'h0000_001D;
      m_pre = 0; m_ien = 0; m_cmp = 0; m_cnt = 0; m_sr = 0;
    end else begin
      setm = 0;
      nc = m_cnt;
      if (m_ctrl[0] && tk) begin
        nc = (!m_ctrl[9] && m_cnt == m_cmp) ? '0 : m_cnt + 1'b1;
        if (nc == m_cmp) setm = setm | 32'h01;
        if (m_cnt == MAXV) setm = setm | 32'h20;
      end
      clrm = (wr && a == 4'd2) ? (d & 32'h21) : 32'h0;
      m_sr = (m_sr & ~clrm) | setm;
      if (wr && a == 4'd0) begin
        if (!m_ctrl[0] && d[0] && d[1]) nc = '0;
        m_ctrl = d & ~32'h0000_8000;
      end
      if (wr && a == 4'd1) m_pre = d;
      if (wr && a == 4'd3) m_ien = d;
      if (wr && a == 4'd4) m_cmp = d[CW-1:0];
      m_cnt = nc;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_cycle(input logic wr, input logic [3:0] a,
                          input logic [31:0] d, input logic tk);
    @(negedge clk);
    wr_en = wr; addr = a; wdata = d; tick = tk; rd_en = 1'b0;
    @(posedge clk);
    m_step(wr, a, d, tk);
    #1;
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic check_irq(input string tag);
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq()});
  endtask

  task automatic check_reg(input string tag, input logic [3:0] a);
    rd_en = 1'b1; addr = a;
    #0.5;
    check($sformatf("%s reg%0d", tag, a), rdata, m_read(a));
    rd_en = 1'b0;
  endtask

  task automatic check_all(input string tag);
    check_reg(tag, 4'd0); check_reg(tag, 4'd1); check_reg(tag, 4'd2);
    check_reg(tag, 4'd3); check_reg(tag, 4'd4); check_reg(tag, 4'd9);
    check_reg(tag, 4'd7);
    check_irq(tag);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] a;
    logic [31:0] d;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 reset");

    // R2 register map and ignored writes
    do_cycle(1, 4'd1, 32'hA5A5_1234, 0);
    do_cycle(1, 4'd3, 32'hFFFF_FFFF, 0);
    do_cycle(1, 4'd4, 32'h0000_0105, 0);
    do_cycle(1, 4'd5, 32'h0000_DEAD, 0);
    do_cycle(1, 4'd9, 32'h0000_0077, 0);
    check_all("R2 map");

    // R3/R6/R11 free-run counting to a compare match
    do_cycle(1, 4'd3, 32'h21, 0);
    do_cycle(1, 4'd0, 32'h201, 0);
    for (int i = 0; i < 5; i++) begin
      do_cycle(0, 4'd0, 0, 1);
      check_all("R6 count");
    end
    check_all("R11 irq");

    // R9 write-one-to-clear
    do_cycle(1, 4'd2, 32'h20, 0);
    check_all("R9 zero bit");
    do_cycle(1, 4'd2, 32'hFFFF_FFDF, 0);
    check_all("R9 clear");

    // R12 compare change while enabled
    do_cycle(1, 4'd4, 32'h8, 1);
    for (int i = 0; i < 3; i++) begin
      do_cycle(0, 4'd0, 0, 1);
      check_all("R12 cmp");
    end
    do_cycle(1, 4'd2, 32'h01, 0);

    // R10 set beats clear
    do_cycle(1, 4'd4, m_cnt + 1, 0);
    do_cycle(1, 4'd2, 32'h01, 1);
    check_all("R10 set-wins");

    // R8 rollover in free-run
    for (int i = 0; i < 260; i++) begin
      do_cycle(0, 4'd0, 0, 1);
      check_irq("R8 run");
    end
    check_all("R8 wrap");

    // R3 hold while disabled
    do_cycle(1, 4'd0, 32'h200, 0);
    for (int i = 0; i < 4; i++) do_cycle(0, 4'd0, 0, 1);
    check_all("R3 hold");

    // R4 enable mode
    do_cycle(1, 4'd0, 32'h203, 1);
    check_all("R4 clear");
    do_cycle(0, 4'd0, 0, 1);
    do_cycle(0, 4'd0, 0, 1);
    do_cycle(1, 4'd0, 32'h200, 0);
    do_cycle(1, 4'd0, 32'h201, 0);
    check_all("R4 resume");

    // R7 restart mode
    do_cycle(1, 4'd4, 32'h3, 0);
    do_cycle(1, 4'd0, 32'h001, 0);
    for (int i = 0; i < 10; i++) begin
      do_cycle(0, 4'd0, 0, 1);
      check_all("R7 restart");
    end

    // R5 software reset
    do_cycle(1, 4'd0, 32'h0000_061D, 0);
    do_cycle(1, 4'd3, 32'h21, 0);
    do_cycle(1, 4'd0, 32'hFFFF_8000, 1);
    check_all("R5 srst");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 8)
        0: a = 4'd0; 1: a = 4'd1; 2: a = 4'd2; 3: a = 4'd3;
        4: a = 4'd4; 5: a = 4'd9; 6: a = 4'd6; default: a = 4'd0;
      endcase
      d = $urandom;
      if (a == 4'd0) begin
        d[15] = (($urandom % 16) == 0);
        d[0]  = (($urandom % 4) != 0);
      end
      if (($urandom % 3) == 0) do_cycle(1, a, d, 1'($urandom));
      else                     do_cycle(0, 4'd0, 0, 1);
      check_irq("R11 random");
      if ((i % 8) == 0) check_all("R2 random");
    end

    finish_run();
  end
endmodule